// File: doc/BRIEF.md
# Banked Data Address Unit

This block turns a data-memory access request from an 8-bit CPU into a 9-bit RAM address, a write data bus and a pair of one-cycle read and write strobes. A request carries the 7-bit file field of the instruction, two direct bank-select bits and one indirect bank bit taken from the status register. Normally the address is the bank-select pair placed above the file field.

The file offset zero is an alias in every bank. Naming it sends the access through an 8-bit pointer register, which is extended upward by the indirect bank bit. The pointer register itself sits at file offset four in every bank and lives inside this block, so it can be loaded and read through the ordinary request path without any RAM traffic. When the effective address resolves back onto the alias offset, which is an indirect self-reference, a read returns zero and a write does nothing.

Each accepted request produces its outputs in the clock after it is sampled. The RAM is read combinationally in that cycle and the read result is presented on a separate bus together with a valid flag.

Top module: `data_addr_unit`

## Requirements
- R1: While reset is held and right after it, ramWe, ramOe and rdValid are low and the pointer register holds 00h, so a read of file offset 04h returns 00h.
- R2: For a request whose file field is not 00h, ramAddr in the following cycle equals {bankSel, fileField}, with bankSel as the two high bits.
- R3: For a request whose file field is 00h, the effective address is {indBank, pointer}, with indBank as bit 8, and it is shown on ramAddr in the following cycle.
- R4: A write request whose effective address has an offset (low 7 bits) other than 00h and 04h raises ramWe for exactly the following cycle with ramDataOut equal to wrData, and ramOe stays low.
- R5: A read request whose effective offset is not 00h or 04h raises ramOe for the following cycle, ramWe stays low, and rdData equals the RAM byte at that address while rdValid is high.
- R6: A read whose effective offset is 00h returns rdData = 00h with rdValid high and ramOe low.
- R7: A write whose effective offset is 00h raises no ramWe and leaves the pointer and the RAM contents unchanged.
- R8: A write whose effective offset is 04h, in any bank, loads wrData into the pointer without raising ramWe; a read at offset 04h returns the pointer with ramOe low.
- R9: In a cycle after no request, ramWe, ramOe and rdValid are all low; ramWe and ramOe are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqRead | input | 1 | Read request for this cycle |
| reqWrite | input | 1 | Write request for this cycle |
| fileField | input | 7 | File field of the instruction |
| bankSel | input | 2 | Direct bank-select bits |
| indBank | input | 1 | Indirect bank bit |
| wrData | input | 8 | Data to store |
| ramDataIn | input | 8 | Read data from the RAM |
| ramAddr | output | 9 | RAM address |
| ramDataOut | output | 8 | RAM write data |
| ramWe | output | 1 | RAM write enable, one cycle per store |
| ramOe | output | 1 | RAM output enable during reads |
| rdData | output | 8 | Read result to the CPU |
| rdValid | output | 1 | rdData holds a read result |

## Verification
The assertions assume that a read request and a write request are never raised in the same cycle, and that the request inputs are steady around the sampling edge. The bench chooses one operation per access, drives inputs only on the falling edge and drops the request before checking, so both conditions always hold. Random accesses are weighted toward file offsets 00h and 04h so that pointer loads, alias redirection and self-reference occur often, and directed cases put the pointer on offsets 00h and 04h of the upper bank.

// File: rtl/adu_pkg.sv
package adu_pkg;

  // Where an access lands once the effective address is known
  typedef enum logic [1:0] {
    TGT_RAM  = 2'd0,
    TGT_PTR  = 2'd1,
    TGT_NULL = 2'd2
  } aduTarget_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic ptrLoad;   // load pointer from write data this edge
    logic capture;   // latch address and write data this edge
    logic selPtr;    // read result comes from pointer
    logic selZero;   // read result is forced to zero
  } aduStrobe_t;

endpackage

// File: rtl/adu_ctrl.sv
module adu_ctrl
  import adu_pkg::*;
#(
  parameter int FILE_W    = 7,
  parameter int ALIAS_OFS = 0,
  parameter int PTR_OFS   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqRead,
  input  logic              reqWrite,
  input  logic [FILE_W-1:0] effOfs,
  output aduStrobe_t        strobe,
  output logic              ramWe,
  output logic              ramOe,
  output logic              rdValid
);

  localparam logic [FILE_W-1:0] ALIAS_IDX = FILE_W'(ALIAS_OFS);
  localparam logic [FILE_W-1:0] PTR_IDX   = FILE_W'(PTR_OFS);

  aduTarget_e target;
  logic weQ, oeQ, validQ, selPtrQ, selZeroQ;

  always_comb begin
    if (effOfs == ALIAS_IDX)    target = TGT_NULL;
    else if (effOfs == PTR_IDX) target = TGT_PTR;
    else                        target = TGT_RAM;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weQ      <= 1'b0;
      oeQ      <= 1'b0;
      validQ   <= 1'b0;
      selPtrQ  <= 1'b0;
      selZeroQ <= 1'b0;
    end else begin
      weQ      <= reqWrite && (target == TGT_RAM);
      oeQ      <= reqRead  && (target == TGT_RAM);
      validQ   <= reqRead;
      selPtrQ  <= reqRead  && (target == TGT_PTR);
      selZeroQ <= reqRead  && (target == TGT_NULL);
    end
  end

  always_comb begin
    strobe.ptrLoad = reqWrite && (target == TGT_PTR);
    strobe.capture = reqRead || reqWrite;
    strobe.selPtr  = selPtrQ;
    strobe.selZero = selZeroQ;
  end

  assign ramWe   = weQ;
  assign ramOe   = oeQ;
  assign rdValid = validQ;

endmodule

// File: rtl/adu_datapath.sv
module adu_datapath
  import adu_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 8,
  parameter int FILE_W    = 7,
  parameter int ALIAS_OFS = 0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [FILE_W-1:0]        fileField,
  input  logic [ADDR_W-FILE_W-1:0] bankSel,
  input  logic [ADDR_W-DATA_W-1:0] indBank,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [DATA_W-1:0]        ramDataIn,
  input  aduStrobe_t               strobe,
  output logic [FILE_W-1:0]        effOfs,
  output logic [ADDR_W-1:0]        ramAddr,
  output logic [DATA_W-1:0]        ramDataOut,
  output logic [DATA_W-1:0]        rdData
);

  localparam logic [FILE_W-1:0] ALIAS_IDX = FILE_W'(ALIAS_OFS);

  logic [DATA_W-1:0] ptrQ;
  logic [ADDR_W-1:0] effAddr;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic              aliasHit;

  // Alias in the file field redirects through the pointer
  assign aliasHit = (fileField == ALIAS_IDX);
  assign effAddr  = aliasHit ? {indBank, ptrQ} : {bankSel, fileField};
  assign effOfs   = effAddr[FILE_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (strobe.ptrLoad) begin
      ptrQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else if (strobe.capture) begin
      addrQ <= effAddr;
      dataQ <= wrData;
    end
  end

  always_comb begin
    if (strobe.selZero)     rdData = '0;
    else if (strobe.selPtr) rdData = ptrQ;
    else                    rdData = ramDataIn;
  end

  assign ramAddr    = addrQ;
  assign ramDataOut = dataQ;

endmodule

// File: rtl/data_addr_unit.sv
module data_addr_unit
  import adu_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 8,
  parameter int FILE_W    = 7,
  parameter int ALIAS_OFS = 0,
  parameter int PTR_OFS   = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqRead,
  input  logic                     reqWrite,
  input  logic [FILE_W-1:0]        fileField,
  input  logic [ADDR_W-FILE_W-1:0] bankSel,
  input  logic [ADDR_W-DATA_W-1:0] indBank,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [DATA_W-1:0]        ramDataIn,
  output logic [ADDR_W-1:0]        ramAddr,
  output logic [DATA_W-1:0]        ramDataOut,
  output logic                     ramWe,
  output logic                     ramOe,
  output logic [DATA_W-1:0]        rdData,
  output logic                     rdValid
);

  aduStrobe_t        strobe;
  logic [FILE_W-1:0] effOfs;

  adu_ctrl #(
    .FILE_W   (FILE_W),
    .ALIAS_OFS(ALIAS_OFS),
    .PTR_OFS  (PTR_OFS)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqRead (reqRead),
    .reqWrite(reqWrite),
    .effOfs  (effOfs),
    .strobe  (strobe),
    .ramWe   (ramWe),
    .ramOe   (ramOe),
    .rdValid (rdValid)
  );

  adu_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .FILE_W   (FILE_W),
    .ALIAS_OFS(ALIAS_OFS)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .fileField (fileField),
    .bankSel   (bankSel),
    .indBank   (indBank),
    .wrData    (wrData),
    .ramDataIn (ramDataIn),
    .strobe    (strobe),
    .effOfs    (effOfs),
    .ramAddr   (ramAddr),
    .ramDataOut(ramDataOut),
    .rdData    (rdData)
  );

endmodule

// File: rtl/data_addr_unit_chk.sv
module data_addr_unit_chk #(
  parameter int ADDR_W    = 9,
  parameter int FILE_W    = 7,
  parameter int ALIAS_OFS = 0,
  parameter int PTR_OFS   = 4
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     reqRead,
  input logic                     reqWrite,
  input logic [FILE_W-1:0]        fileField,
  input logic [ADDR_W-FILE_W-1:0] bankSel,
  input logic [ADDR_W-1:0]        ramAddr,
  input logic                     ramWe,
  input logic                     ramOe,
  input logic                     rdValid
);

  localparam logic [FILE_W-1:0] ALIAS_IDX = FILE_W'(ALIAS_OFS);
  localparam logic [FILE_W-1:0] PTR_IDX   = FILE_W'(PTR_OFS);

  // R1
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reset_quiet_chk: assert (!ramWe && !ramOe && !rdValid);
    end
  end

  // R2
  direct_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((reqRead || reqWrite) && fileField != ALIAS_IDX) |=> ramAddr == $past({bankSel, fileField}));

  // R4
  we_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> $past(reqWrite));

  // R5
  oe_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramOe |-> $past(reqRead));

  // R5
  valid_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(reqRead));

  // R6
  no_oe_at_reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramOe |-> (ramAddr[FILE_W-1:0] != ALIAS_IDX && ramAddr[FILE_W-1:0] != PTR_IDX));

  // R7
  no_we_at_reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (ramAddr[FILE_W-1:0] != ALIAS_IDX && ramAddr[FILE_W-1:0] != PTR_IDX));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!reqRead && !reqWrite) |=> (!ramWe && !ramOe && !rdValid));

  // R9
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ramWe && ramOe));

endmodule

bind data_addr_unit data_addr_unit_chk #(
  .ADDR_W   (ADDR_W),
  .FILE_W   (FILE_W),
  .ALIAS_OFS(ALIAS_OFS),
  .PTR_OFS  (PTR_OFS)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .reqRead  (reqRead),
  .reqWrite (reqWrite),
  .fileField(fileField),
  .bankSel  (bankSel),
  .ramAddr  (ramAddr),
  .ramWe    (ramWe),
  .ramOe    (ramOe),
  .rdValid  (rdValid)
);

// File: tb/data_addr_unit_tb.sv
`timescale 1ns/1ps
module data_addr_unit_tb_top;

  logic       clk;
  logic       rstN;
  logic       reqRead, reqWrite;
  logic [6:0] fileField;
  logic [1:0] bankSel;
  logic [0:0] indBank;
  logic [7:0] wrData, ramDataIn;
  logic [8:0] ramAddr;
  logic [7:0] ramDataOut, rdData;
  logic       ramWe, ramOe, rdValid;

  logic [7:0] mem [512];
  logic [7:0] memModel [512];
  logic [7:0] ptrModel;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  data_addr_unit dut_i (
    .clk(clk), .rstN(rstN), .reqRead(reqRead), .reqWrite(reqWrite),
    .fileField(fileField), .bankSel(bankSel), .indBank(indBank),
    .wrData(wrData), .ramDataIn(ramDataIn), .ramAddr(ramAddr),
    .ramDataOut(ramDataOut), .ramWe(ramWe), .ramOe(ramOe),
    .rdData(rdData), .rdValid(rdValid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // RAM model: combinational read, write on the clock edge
  assign ramDataIn = mem[ramAddr];
  always @(posedge clk) if (ramWe) mem[ramAddr] <= ramDataOut;

  function automatic logic [7:0] seedByte(input int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  function automatic logic [8:0] effAddrOf(input logic [6:0] f, input logic [1:0] b,
                                           input logic ib, input logic [7:0] p);
    return (f == 7'd0) ? {ib, p} : {b, f};
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // One access: drive at a falling edge, check one cycle later
  task automatic access(input bit isW, input logic [6:0] f, input logic [1:0] b,
                        input logic ib, input logic [7:0] d);
    logic [8:0] ea;
    logic [6:0] ofs;
    string addrTag;
    @(negedge clk);
    reqRead = !isW; reqWrite = isW;
    fileField = f; bankSel = b; indBank = ib; wrData = d;
    ea  = effAddrOf(f, b, ib, ptrModel);
    ofs = ea[6:0];
    addrTag = (f == 7'd0) ? "R3" : "R2";
    @(negedge clk);
    reqRead = 1'b0; reqWrite = 1'b0;
    if (isW) begin
      chk("R5", "ramOe on write", 16'(ramOe), 16'd0);
      chk("R5", "rdValid on write", 16'(rdValid), 16'd0);
      if (ofs == 7'd0) begin
        chk("R7", "ramWe self-ref write", 16'(ramWe), 16'd0);
      end else if (ofs == 7'd4) begin
        chk("R8", "ramWe pointer write", 16'(ramWe), 16'd0);
        ptrModel = d;
      end else begin
        chk("R4", "ramWe", 16'(ramWe), 16'd1);
        chk(addrTag, "ramAddr", 16'(ramAddr), 16'(ea));
        chk("R4", "ramDataOut", 16'(ramDataOut), 16'(d));
        memModel[ea] = d;
      end
    end else begin
      chk("R5", "ramWe on read", 16'(ramWe), 16'd0);
      chk("R5", "rdValid", 16'(rdValid), 16'd1);
      if (ofs == 7'd0) begin
        chk("R6", "ramOe self-ref", 16'(ramOe), 16'd0);
        chk("R6", "rdData self-ref", 16'(rdData), 16'd0);
      end else if (ofs == 7'd4) begin
        chk("R8", "ramOe pointer read", 16'(ramOe), 16'd0);
        chk("R8", "rdData pointer", 16'(rdData), 16'(ptrModel));
      end else begin
        chk("R5", "ramOe", 16'(ramOe), 16'd1);
        chk(addrTag, "ramAddr", 16'(ramAddr), 16'(ea));
        chk("R5", "rdData", 16'(rdData), 16'(memModel[ea]));
      end
    end
  endtask

  task automatic idleCheck();
    @(negedge clk);
    chk("R9", "idle ramWe", 16'(ramWe), 16'd0);
    chk("R9", "idle ramOe", 16'(ramOe), 16'd0);
    chk("R9", "idle rdValid", 16'(rdValid), 16'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 512; i++) begin
      mem[i] = seedByte(i);
      memModel[i] = seedByte(i);
    end
    ptrModel = 8'h00;
    rstN = 1'b0;
    reqRead = 1'b0; reqWrite = 1'b0;
    fileField = '0; bankSel = '0; indBank = '0; wrData = '0;
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    chk("R1", "ramWe in reset", 16'(ramWe), 16'd0);
    chk("R1", "ramOe in reset", 16'(ramOe), 16'd0);
    chk("R1", "rdValid in reset", 16'(rdValid), 16'd0);
    rstN = 1'b1;
    idleCheck();
    // R1: pointer reads 00h after reset
    access(1'b0, 7'd4, 2'd2, 1'b0, 8'h00);

    // Directed: plain direct read and write
    access(1'b1, 7'h25, 2'd1, 1'b0, 8'hA5);
    access(1'b0, 7'h25, 2'd1, 1'b1, 8'h00);
    idleCheck();
    // R8: pointer load from bank 3, then alias access through it
    access(1'b1, 7'd4, 2'd3, 1'b0, 8'h85);
    access(1'b0, 7'd4, 2'd0, 1'b0, 8'h00);
    access(1'b1, 7'd0, 2'd0, 1'b1, 8'h3C);   // R3: to 0x185
    access(1'b0, 7'h05, 2'd3, 1'b0, 8'h00);  // R2: same location directly
    // R6/R7: pointer on alias offset of upper bank
    access(1'b1, 7'd4, 2'd1, 1'b0, 8'h80);
    access(1'b0, 7'd0, 2'd2, 1'b1, 8'h00);
    access(1'b1, 7'd0, 2'd2, 1'b1, 8'hEE);
    access(1'b0, 7'd4, 2'd0, 1'b0, 8'h00);   // pointer still 80h
    // R8: pointer aimed at its own offset
    access(1'b1, 7'd4, 2'd0, 1'b0, 8'h84);
    access(1'b0, 7'd0, 2'd1, 1'b1, 8'h00);
    access(1'b1, 7'd0, 2'd1, 1'b0, 8'h5A);   // indirect load of pointer
    access(1'b0, 7'd4, 2'd2, 1'b0, 8'h00);
    idleCheck();

    // Random mix weighted toward offsets 0 and 4
    for (int n = 0; n < 500; n++) begin
      int sel;
      logic [6:0] f;
      sel = $urandom % 10;
      if (sel < 2)       f = 7'd0;
      else if (sel < 4)  f = 7'd4;
      else               f = 7'($urandom);
      access(1'($urandom), f, 2'($urandom), 1'($urandom), 8'($urandom));
      if (($urandom % 8) == 0) idleCheck();
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule